// File: doc/BRIEF.md
# Double-Buffered Peripheral-to-Memory Stream Engine

This block moves words from one fixed peripheral data register into memory, one stream at a time. Software programs a word count, a peripheral address, two memory base addresses and a burst threshold, then sets the enable bit. Each word the peripheral offers (`per_req`) is taken into a small FIFO (`per_ack`). Once the FIFO holds the threshold number of words, or every word still owed in the round, the engine drains it to memory as a burst over a request/ready port. Only the memory address advances; the peripheral address never moves.

In double-buffer mode the engine swaps between base 0 and base 1 at every round end. Circular operation is then forced on and the count reloads, so software can refill whichever buffer is idle. Completion, half-way and error conditions raise sticky flags. The flags are cleared by a write-one-to-clear register, and a new start is refused while any flag is still set. The controller has three states. IDLE waits for an accepted enable (IDLE→FILL). FILL gathers words (FILL→BURST at the threshold, FILL→IDLE on stop). BURST writes to memory (BURST→FILL when the FIFO empties or a circular round wraps; BURST→IDLE on stop, on the end of a single-shot run, or on a target-write error).

Top module: `dbuf_dma_stream`

## Requirements
- R1: After reset, `stream_on` is 0, `cur_tgt` is 0, `flag_tc`, `flag_ht`, `flag_te` and `irq` are 0, and neither `mem_req` nor `per_ack` is asserted.
- R2: Register map: offset 0 is control, offset 1 is count, offset 3 is base 0 and offset 4 is base 1. Control bits are: bit0 enable, bit1 circular, bit2 double-buffer, bit3 initial target, bit4 complete interrupt enable, bit5 half interrupt enable, bit6 error interrupt enable, bit7 memory increment. With circular and double-buffer both clear, exactly count words are taken from `per_data` in arrival order and written to base0 + 4*i. The stream then turns itself off with `rem_cnt` at 0 and `flag_tc` set.
- R3: With the memory-increment bit clear, every beat of a run is written to the base address itself.
- R4: Bits 1:0 at offset 5 select the burst threshold: 0 means one word, 1 means half the FIFO, and 2 or 3 mean a full FIFO. `mem_req` stays low until the FIFO holds the threshold number of words, or all words still owed in the round.
- R5: In double-buffer mode, successive rounds alternate between base 0 and base 1 and `cur_tgt` toggles at each round end. The stream keeps running even though the circular bit is clear, and `rem_cnt` reloads to count.
- R6: In circular mode without double-buffering, each round restarts at the same base and `cur_tgt` does not change. Writing control with bit0 at 0 stops a running stream, and `stream_on` and `mem_req` are low in the cycle after the write.
- R7: `flag_ht` sets when `rem_cnt` reaches floor(count/2), provided count is at least 2.
- R8: A control write with bit0 set does not start the stream while any flag is set or while count is 0.
- R9: A write to offset 6 clears each flag whose bit is 1: bit0 `flag_tc`, bit1 `flag_ht`, bit2 `flag_te`. Flags whose bit is 0 keep their value.
- R10: While the stream runs, a write to the base register of the active target is ignored, and a write to the idle target's base register takes effect.
- R11: In double-buffer mode, if the last beat of a round is accepted in the same cycle as a write to the next target's base register, `flag_te` and `flag_tc` both set and the stream turns off.
- R12: `irq` is high exactly when some flag is set and its interrupt enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | AW | Register write data |
| per_req | input | 1 | Peripheral has a word ready |
| per_data | input | DW | Peripheral data register value |
| per_ack | output | 1 | Word taken this cycle |
| per_addr | output | AW | Programmed peripheral address (fixed) |
| mem_req | output | 1 | Memory write request |
| mem_rdy | input | 1 | Memory accepts the beat |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| stream_on | output | 1 | Stream enabled |
| cur_tgt | output | 1 | Current memory target |
| rem_cnt | output | CW | Words left to write in this round |
| flag_tc | output | 1 | Round complete flag |
| flag_ht | output | 1 | Half-way flag |
| flag_te | output | 1 | Target-write error flag |
| irq | output | 1 | Interrupt |

## Verification
A single-shot run with a two-word threshold shows the order of data and addresses, self-termination and the half-way flag. A run with the increment disabled, with fewer words than the threshold, separates the fixed-address path and the drain-on-remainder rule from normal bursts. Three double-buffer rounds with a full threshold tell ping-pong swapping and count reload apart from single-buffer circular wrap, which is run separately with a one-word threshold. A final double-buffer run retargets the idle base and attempts to change the active base in mid-round. It then stalls memory so that the last beat and a write to the next target fall in the same cycle, which exposes the error path.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_BURST = 2'd2
    } dma_state_t;

    localparam logic [2:0] RA_CTRL    = 3'd0;
    localparam logic [2:0] RA_COUNT   = 3'd1;
    localparam logic [2:0] RA_PADDR   = 3'd2;
    localparam logic [2:0] RA_MBASE0  = 3'd3;
    localparam logic [2:0] RA_MBASE1  = 3'd4;
    localparam logic [2:0] RA_FIFOCFG = 3'd5;
    localparam logic [2:0] RA_CLEAR   = 3'd6;

    localparam int CB_EN   = 0;
    localparam int CB_CIRC = 1;
    localparam int CB_DBM  = 2;
    localparam int CB_CT   = 3;
    localparam int CB_TCIE = 4;
    localparam int CB_HTIE = 5;
    localparam int CB_TEIE = 6;
    localparam int CB_MINC = 7;

    localparam int FLAG_TC = 0;
    localparam int FLAG_HT = 1;
    localparam int FLAG_TE = 2;
    localparam int NFLAGS  = 3;

endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DW-1:0]              din,
    input  logic                       pop,
    output logic [DW-1:0]              dout,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST_IX = PW'(DEPTH - 1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ix, rd_ix;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ix <= '0;
            rd_ix <= '0;
            count <= '0;
        end else begin
            if (push) begin
                store[wr_ix] <= din;
                wr_ix <= (wr_ix == LAST_IX) ? '0 : wr_ix + 1'b1;
            end
            if (pop) begin
                rd_ix <= (rd_ix == LAST_IX) ? '0 : rd_ix + 1'b1;
            end
            count <= count + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    assign dout = store[rd_ix];

    assert_fifo_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> (count < (PW+1)'(DEPTH)));
    assert_fifo_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> (count != '0));

endmodule

// File: rtl/dma_flags.sv
module dma_flags
    import dma_stream_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set_v,
    input  logic              clr_we,
    input  logic [NFLAGS-1:0] clr_bits,
    input  logic [NFLAGS-1:0] ie,
    output logic [NFLAGS-1:0] flags,
    output logic              irq
);
    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                      flags[g] <= 1'b0;
            else if (set_v[g])               flags[g] <= 1'b1;
            else if (clr_we && clr_bits[g])  flags[g] <= 1'b0;
        end
    end

    assign irq = |(flags & ie);

    assert_irq_has_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
    assert_set_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_v[FLAG_TC] |=> flags[FLAG_TC]);

endmodule

// File: rtl/dbuf_dma_stream.sv
module dbuf_dma_stream
    import dma_stream_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int CW         = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          per_req,
    input  logic [DW-1:0] per_data,
    output logic          per_ack,
    output logic [AW-1:0] per_addr,
    output logic          mem_req,
    input  logic          mem_rdy,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          stream_on,
    output logic          cur_tgt,
    output logic [CW-1:0] rem_cnt,
    output logic          flag_tc,
    output logic          flag_ht,
    output logic          flag_te,
    output logic          irq
);
    localparam int FCW = $clog2(FIFO_DEPTH) + 1;
    localparam logic [FCW-1:0] DEPTH_C = FCW'(FIFO_DEPTH);
    localparam logic [FCW-1:0] HALF_C  = FCW'((FIFO_DEPTH > 1) ? FIFO_DEPTH / 2 : 1);

    dma_state_t state, state_nx;

    logic          en, circ, dbm, ct, tcie, htie, teie, minc;
    logic [CW-1:0] count_r, rem, offset;
    logic [AW-1:0] paddr, mbase0, mbase1;
    logic [1:0]    thr_sel;

    logic [FCW-1:0]    f_cnt, fill_next, thr_words;
    logic              f_push, f_pop, f_flush;
    logic [NFLAGS-1:0] flags;

    logic wr_ctrl, start_ok, stop, beat, last, looping, next_wr, te_hit, wrap, finish, ht_hit;
    logic [CW-1:0] rem_after;

    // register-write decode
    always_comb begin
        wr_ctrl   = cfg_we && (cfg_addr == RA_CTRL);
        start_ok  = wr_ctrl && !en && cfg_wdata[CB_EN] && (flags == '0) && (count_r != '0);
        stop      = wr_ctrl && en && !cfg_wdata[CB_EN];
        next_wr   = cfg_we && (ct ? (cfg_addr == RA_MBASE0) : (cfg_addr == RA_MBASE1));
    end

    // transfer events
    always_comb begin
        beat      = (state == ST_BURST) && mem_rdy;
        last      = beat && (rem == CW'(1));
        looping   = circ || dbm;
        te_hit    = last && dbm && next_wr;
        wrap      = last && looping && !te_hit;
        finish    = last && !looping;
        rem_after = rem - 1'b1;
        ht_hit    = beat && (count_r >= CW'(2)) && (rem_after == (count_r >> 1));
        unique case (thr_sel)
            2'd0:    thr_words = FCW'(1);
            2'd1:    thr_words = HALF_C;
            default: thr_words = DEPTH_C;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_ok) state_nx = ST_FILL;
            ST_FILL: begin
                if (stop)
                    state_nx = ST_IDLE;
                else if (fill_next != '0 &&
                         (fill_next >= thr_words || CW'(fill_next) == rem))
                    state_nx = ST_BURST;
            end
            ST_BURST: begin
                if (stop || te_hit || finish)
                    state_nx = ST_IDLE;
                else if (beat && f_cnt == FCW'(1))
                    state_nx = ST_FILL;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        f_push    = (state == ST_FILL) && per_req && (f_cnt < DEPTH_C) && (CW'(f_cnt) < rem);
        fill_next = f_cnt + FCW'(f_push);
        mem_req   = (state == ST_BURST);
        f_pop     = beat;
        f_flush   = stop || te_hit || finish || start_ok;
        per_ack   = f_push;
    end

    // configuration and progress registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {en, circ, dbm, ct, tcie, htie, teie, minc} <= '0;
            count_r <= '0;
            rem     <= '0;
            offset  <= '0;
            paddr   <= '0;
            mbase0  <= '0;
            mbase1  <= '0;
            thr_sel <= '0;
        end else begin
            if (wr_ctrl && !en) begin
                circ <= cfg_wdata[CB_CIRC];
                dbm  <= cfg_wdata[CB_DBM];
                ct   <= cfg_wdata[CB_CT];
                tcie <= cfg_wdata[CB_TCIE];
                htie <= cfg_wdata[CB_HTIE];
                teie <= cfg_wdata[CB_TEIE];
                minc <= cfg_wdata[CB_MINC];
                en   <= start_ok;
            end else if (stop) begin
                en <= 1'b0;
            end
            if (!en && cfg_we && cfg_addr == RA_COUNT)   count_r <= cfg_wdata[CW-1:0];
            if (!en && cfg_we && cfg_addr == RA_PADDR)   paddr   <= cfg_wdata;
            if (!en && cfg_we && cfg_addr == RA_FIFOCFG) thr_sel <= cfg_wdata[1:0];
            if (cfg_we && cfg_addr == RA_MBASE0 && (!en || ct))  mbase0 <= cfg_wdata;
            if (cfg_we && cfg_addr == RA_MBASE1 && (!en || !ct)) mbase1 <= cfg_wdata;

            if (start_ok) begin
                rem    <= count_r;
                offset <= '0;
            end else if (en) begin
                if (te_hit || finish) begin
                    en  <= 1'b0;
                    rem <= '0;
                end else if (wrap) begin
                    rem    <= count_r;
                    offset <= '0;
                    if (dbm) ct <= ~ct;
                end else if (beat) begin
                    rem <= rem_after;
                    if (minc) offset <= offset + 1'b1;
                end
            end
        end
    end

    dma_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (f_flush),
        .push  (f_push),
        .din   (per_data),
        .pop   (f_pop),
        .dout  (mem_wdata),
        .count (f_cnt)
    );

    dma_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_v    ({te_hit, ht_hit, last}),
        .clr_we   (cfg_we && cfg_addr == RA_CLEAR),
        .clr_bits (cfg_wdata[NFLAGS-1:0]),
        .ie       ({teie, htie, tcie}),
        .flags    (flags),
        .irq      (irq)
    );

    assign mem_addr  = (ct ? mbase1 : mbase0) + (AW'(offset) << 2);
    assign per_addr  = paddr;
    assign stream_on = en;
    assign cur_tgt   = ct;
    assign rem_cnt   = rem;
    assign flag_tc   = flags[FLAG_TC];
    assign flag_ht   = flags[FLAG_HT];
    assign flag_te   = flags[FLAG_TE];

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_on |-> (!mem_req && !per_ack));
    assert_start_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stream_on) |-> $past(flags == '0));
    assert_dbm_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && dbm) |=> (cur_tgt != $past(cur_tgt)));
    assert_err_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_te) |-> !stream_on);

endmodule

// File: tb/dbuf_dma_stream_tb_top.sv
`timescale 1ns/1ps
module dbuf_dma_stream_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        per_req = 1'b0;
    logic [31:0] per_data;
    logic        per_ack;
    logic [31:0] per_addr;
    logic        mem_req, mem_rdy;
    logic [31:0] mem_addr, mem_wdata;
    logic        stream_on, cur_tgt;
    logic [15:0] rem_cnt;
    logic        flag_tc, flag_ht, flag_te, irq;

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";

    logic [63:0] sb_q[$];
    int          sb_n = 0;
    logic        gate = 1'b1;
    logic [31:0] src = 32'h100;
    logic        take = 1'b0;
    logic        hit = 1'b0;
    logic [31:0] ha, hd;
    int          ack_cnt = 0;
    int          acks_at_req = 0;
    bit          seen_req = 1'b0;

    assign mem_rdy  = gate && (sb_n > 0);
    assign per_data = src;

    dbuf_dma_stream dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .per_req(per_req), .per_data(per_data), .per_ack(per_ack), .per_addr(per_addr),
        .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .stream_on(stream_on), .cur_tgt(cur_tgt), .rem_cnt(rem_cnt),
        .flag_tc(flag_tc), .flag_ht(flag_ht), .flag_te(flag_te), .irq(irq)
    );

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // monitor: sample between edges, score after the accepting edge
    always @(negedge clk) begin
        take = per_ack;
        hit  = mem_req && mem_rdy;
        ha   = mem_addr;
        hd   = mem_wdata;
        if (!seen_req && mem_req) begin
            seen_req    = 1'b1;
            acks_at_req = ack_cnt;
        end
        if (per_ack) ack_cnt++;
    end

    always @(posedge clk) begin
        if (take) src <= src + 1;
        if (hit) begin
            #1;
            if (sb_n == 0) begin
                chk(cur_req, "unexpected beat", {ha, hd}, 64'h0);
            end else begin
                logic [63:0] e;
                e = sb_q.pop_front();
                sb_n--;
                chk(cur_req, "beat addr/data", {ha, hd}, e);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #4; end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #4;
        cfg_we = 1'b0;
    endtask

    task automatic push_exp(input logic [31:0] base, input int n, input int stride, input logic [31:0] first);
        for (int i = 0; i < n; i++) begin
            sb_q.push_back({base + 32'(4 * i * stride), first + 32'(i)});
            sb_n++;
        end
    endtask

    task automatic wait_drain();
        int lim = 500;
        while (sb_n != 0 && lim > 0) begin step(1); lim--; end
        chk(cur_req, "scoreboard drained", 64'(sb_n), 64'h0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog all actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] f;
        int lim;
        repeat (3) @(posedge clk);
        #4; rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1", "stream_on", 64'(stream_on), 64'h0);
        chk("R1", "cur_tgt", 64'(cur_tgt), 64'h0);
        chk("R1", "flags", 64'({flag_te, flag_ht, flag_tc}), 64'h0);
        chk("R1", "irq", 64'(irq), 64'h0);
        chk("R1", "mem_req/per_ack", 64'({mem_req, per_ack}), 64'h0);
        per_req = 1'b1;

        // R2 single shot, R7 half flag, R12 irq
        cur_req = "R2";
        wr(3'd1, 6); wr(3'd3, 32'h1000); wr(3'd5, 1);
        push_exp(32'h1000, 6, 1, src);
        wr(3'd0, 32'h91);
        wait_drain(); step(1);
        chk("R2", "stream_on after run", 64'(stream_on), 64'h0);
        chk("R2", "rem_cnt", 64'(rem_cnt), 64'h0);
        chk("R2", "flag_tc", 64'(flag_tc), 64'h1);
        chk("R7", "flag_ht", 64'(flag_ht), 64'h1);
        chk("R12", "irq with complete enabled", 64'(irq), 64'h1);

        // R8 refused start with flags set
        wr(3'd0, 32'h91); step(2);
        chk("R8", "start refused, flags set", 64'({stream_on, mem_req}), 64'h0);

        // R9 selective clear
        wr(3'd6, 1);
        chk("R9", "tc cleared, ht kept", 64'({flag_ht, flag_tc}), 64'h2);
        chk("R12", "irq with only ht set, not enabled", 64'(irq), 64'h0);
        wr(3'd6, 2);
        chk("R9", "all clear", 64'({flag_te, flag_ht, flag_tc}), 64'h0);

        // R8 refused start with count 0
        wr(3'd1, 0); wr(3'd0, 1); step(2);
        chk("R8", "start refused, count 0", 64'(stream_on), 64'h0);

        // R3 fixed memory address, fewer words than threshold
        cur_req = "R3";
        wr(3'd1, 3); wr(3'd3, 32'h2000); wr(3'd5, 2);
        push_exp(32'h2000, 3, 0, src);
        wr(3'd0, 1);
        wait_drain(); step(1);
        chk("R3", "single shot ended", 64'({stream_on, flag_tc}), 64'h1);
        wr(3'd6, 7);

        // R5 double buffer over three rounds, R4 full threshold
        cur_req = "R5";
        wr(3'd1, 4); wr(3'd3, 32'h4000); wr(3'd4, 32'h5000); wr(3'd5, 2);
        f = src;
        push_exp(32'h4000, 4, 1, f);
        push_exp(32'h5000, 4, 1, f + 4);
        push_exp(32'h4000, 4, 1, f + 8);
        seen_req = 1'b0; ack_cnt = 0;
        wr(3'd0, 32'h85);
        wait_drain(); step(6);
        chk("R4", "words taken before first mem_req", 64'(acks_at_req), 64'h4);
        chk("R5", "still running", 64'(stream_on), 64'h1);
        chk("R5", "cur_tgt after three rounds", 64'(cur_tgt), 64'h1);
        chk("R5", "count reloaded", 64'(rem_cnt), 64'h4);
        chk("R4", "full burst pending", 64'(mem_req), 64'h1);
        wr(3'd0, 0);
        chk("R6", "stop clears stream_on/mem_req", 64'({stream_on, mem_req}), 64'h0);
        wr(3'd6, 7);

        // R6 single-buffer circular
        cur_req = "R6";
        wr(3'd1, 2); wr(3'd3, 32'h6000); wr(3'd5, 0);
        f = src;
        push_exp(32'h6000, 2, 1, f);
        push_exp(32'h6000, 2, 1, f + 2);
        wr(3'd0, 32'h83);
        wait_drain(); step(1);
        chk("R6", "running and target kept", 64'({stream_on, cur_tgt}), 64'h2);
        wr(3'd0, 0);
        chk("R6", "stopped", 64'({stream_on, mem_req}), 64'h0);
        wr(3'd6, 7);

        // R10 base writes while running, R11 error on swap collision
        cur_req = "R10";
        wr(3'd1, 3); wr(3'd3, 32'h7000); wr(3'd4, 32'h3000); wr(3'd5, 2);
        f = src;
        push_exp(32'h7000, 3, 1, f);
        push_exp(32'h8000, 2, 1, f + 3);
        wr(3'd0, 32'hC5);
        wr(3'd4, 32'h8000);
        wr(3'd3, 32'h9000);
        wait_drain();
        lim = 100;
        while (!(mem_req && rem_cnt == 16'd1) && lim > 0) begin step(1); lim--; end
        chk("R5", "target toggled to 1", 64'(cur_tgt), 64'h1);
        cur_req = "R11";
        push_exp(32'h8008, 1, 1, f + 5);
        wr(3'd3, 32'hA000);
        chk("R11", "error and complete flags", 64'({flag_te, flag_tc}), 64'h3);
        chk("R11", "stream off", 64'(stream_on), 64'h0);
        chk("R12", "irq with error enabled", 64'(irq), 64'h1);
        step(2);
        chk("R11", "scoreboard empty", 64'(sb_n), 64'h0);

        summary();
        $finish;
    end
endmodule